// File: doc/BRIEF.md
# Prioritized Vectored Bus Interrupter

This block turns change-of-state flags from four input groups into one bus interrupt request. A control register holds a global enable, a per-group enable and a three-bit level code. When a flagged group is enabled and the global enable is set, the block drives exactly one of seven request lines. The line it drives is chosen by the level code. A code of zero turns all seven lines off.

When the bus master acknowledges an interrupt, it presents the acknowledged level on three level-address lines and raises the acknowledge-in signal. The block compares that level with its own. On a match it returns the 16-bit vector of the highest-priority pending group, where group 0 ranks above group 1, group 1 above group 2, and group 2 above group 3. It holds that vector with a data strobe until acknowledge-in falls, and it clears its global enable so that the request is withdrawn. If the level does not match, or the block is not requesting, it relays the acknowledge to the next board in the daisy chain.

The acknowledge logic is a three-state machine:
- ST_IDLE waits for acknowledge-in. It goes to ST_REPLY on a match and to ST_RELAY otherwise.
- ST_REPLY drives the vector and the strobe.
- ST_RELAY forwards the acknowledge.
- Both ST_REPLY and ST_RELAY return to ST_IDLE in the cycle after acknowledge-in is released.

Top module: `vme_irq_unit`

## Requirements
- R1: After reset the control readback is 0, no request line is driven, and every group vector is 0. An acknowledge taken before any vector write returns 0.
- R2: A control write with bit 0 set clears the whole register. Any other write loads the following fields: bit 1 is the global enable, bits 4:2 are the level code, and bits 8+g are the enable for group g. The readback shows these fields in the same positions, and every other bit reads 0.
- R3: A request exists only when some group has its flag set, its group enable set, and the global enable set.
- R4: With a request present and level code k (1 to 7), only irq_o[k-1] is high. With code 0, or with no request, irq_o is 0.
- R5: A matching acknowledge returns the vector of the lowest-numbered group that is both flagged and enabled. The vector for group g is loaded by a write with vec_wr[g] high.
- R6: A matching acknowledge clears the global enable in the same edge that starts the reply. The request lines then drop. If a control write lands in that same cycle, the clear takes precedence.
- R7: An acknowledge whose level differs from the code, or one that arrives while no request exists, is relayed on iack_out. The global enable stays set in this case.
- R8: During a reply, dtack and vec_data stay unchanged until acknowledge-in falls, even if the flags change. Both return to 0 one cycle after the release.
- R9: iack_out is high only while acknowledge-in is high and the block is relaying. It is never high together with dtack, and it falls in the same cycle that acknowledge-in falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control register readback |
| vec_wr | input | 4 | Per-group vector write strobes |
| vec_wdata | input | 16 | Vector write data |
| cos_req | input | 4 | Per-group change-of-state flags |
| irq_o | output | 7 | Request lines; bit k-1 is level k |
| iack_in | input | 1 | Acknowledge daisy-chain input |
| lvl_addr | input | 3 | Acknowledged level (bus address bits 3:1) |
| iack_out | output | 1 | Acknowledge daisy-chain output |
| vec_data | output | 16 | Returned vector, 0 when not replying |
| dtack | output | 1 | Vector valid strobe |

## Verification
Two situations are hard to reach from the ports. The first is a reply in which several groups are pending while lower-numbered groups are masked. The second is a relay that has to leave the enable untouched. The bench reaches both by programming a distinct vector per group and then sweeping every nonzero flag pattern against every level code and every acknowledged level. It also runs directed cases where the group enables mask the top-priority groups, where flags are withdrawn in the middle of a reply, and where an acknowledge arrives while nothing is pending.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;
    localparam int CTL_W   = 16;
    localparam int B_CLEAR = 0;
    localparam int B_GEN   = 1;
    localparam int B_LVL   = 2;
    localparam int B_GRP   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REPLY,
        ST_RELAY
    } ack_state_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import vme_irq_pkg::*;
#(
    parameter int NGRP  = 4,
    parameter int VEC_W = 16,
    parameter int LVL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [CTL_W-1:0]        ctl_wdata,
    input  logic                    ack_clr,
    input  logic [NGRP-1:0]         vec_wr,
    input  logic [VEC_W-1:0]        vec_wdata,
    output logic                    gen_en,
    output logic [LVL_W-1:0]        lvl,
    output logic [NGRP-1:0]         grp_en,
    output logic [VEC_W-1:0]        vec_arr [NGRP],
    output logic [CTL_W-1:0]        ctl_rdata
);
    localparam logic [CTL_W-1:0] USED =
        CTL_W'(((1 << NGRP) - 1) << B_GRP) |
        CTL_W'(((1 << LVL_W) - 1) << B_LVL) |
        CTL_W'(1 << B_GEN) | CTL_W'(1 << B_CLEAR);

    logic unused_wbits;
    assign unused_wbits = ^(ctl_wdata & ~USED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            lvl    <= '0;
            grp_en <= '0;
        end else begin
            if (ctl_wr) begin
                if (ctl_wdata[B_CLEAR]) begin
                    gen_en <= 1'b0;
                    lvl    <= '0;
                    grp_en <= '0;
                end else begin
                    gen_en <= ctl_wdata[B_GEN];
                    lvl    <= ctl_wdata[B_LVL +: LVL_W];
                    grp_en <= ctl_wdata[B_GRP +: NGRP];
                end
            end
            if (ack_clr) gen_en <= 1'b0;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_vec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         vec_arr[g] <= '0;
            else if (vec_wr[g]) vec_arr[g] <= vec_wdata;
        end
    end

    always_comb begin
        ctl_rdata                   = '0;
        ctl_rdata[B_GEN]            = gen_en;
        ctl_rdata[B_LVL +: LVL_W]   = lvl;
        ctl_rdata[B_GRP +: NGRP]    = grp_en;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[B_CLEAR]) |=> (ctl_rdata == '0)) else $error("clear"); // R2
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import vme_irq_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_in,
    input  logic [LVL_W-1:0] lvl_addr,
    input  logic [LVL_W-1:0] own_lvl,
    input  logic             req_valid,
    output logic             take,
    output logic             dtack,
    output logic             iack_out
);
    ack_state_t state, nstate;
    logic       match;

    assign match = req_valid && (own_lvl != '0) && (lvl_addr == own_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        take   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (iack_in) begin
                    nstate = match ? ST_REPLY : ST_RELAY;
                    take   = match;
                end
            end
            ST_REPLY: if (!iack_in) nstate = ST_IDLE;
            ST_RELAY: if (!iack_in) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        dtack    = (state == ST_REPLY);
        iack_out = (state == ST_RELAY) && iack_in;
    end

    AST_RELAY_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        iack_out |-> iack_in) else $error("relay"); // R9
    AST_NO_DUAL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !(dtack && iack_out)) else $error("dual"); // R9
    AST_REPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack && iack_in) |=> dtack) else $error("hold"); // R8
endmodule

// File: rtl/vme_irq_unit.sv
module vme_irq_unit
    import vme_irq_pkg::*;
#(
    parameter int NGRP  = 4,
    parameter int VEC_W = 16,
    parameter int LVL_W = 3,
    localparam int NLVL = (1 << LVL_W) - 1,
    localparam int IDX_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic [NGRP-1:0]   vec_wr,
    input  logic [VEC_W-1:0]  vec_wdata,
    input  logic [NGRP-1:0]   cos_req,
    output logic [NLVL-1:0]   irq_o,
    input  logic              iack_in,
    input  logic [LVL_W-1:0]  lvl_addr,
    output logic              iack_out,
    output logic [VEC_W-1:0]  vec_data,
    output logic              dtack
);
    logic             gen_en, take, req_valid;
    logic [LVL_W-1:0] lvl;
    logic [NGRP-1:0]  grp_en, pend;
    logic [VEC_W-1:0] vec_arr [NGRP];
    logic [IDX_W-1:0] win;
    logic [VEC_W-1:0] vec_q;

    irq_cfg_regs #(.NGRP(NGRP), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ack_clr(take), .vec_wr(vec_wr), .vec_wdata(vec_wdata),
        .gen_en(gen_en), .lvl(lvl), .grp_en(grp_en), .vec_arr(vec_arr),
        .ctl_rdata(ctl_rdata)
    );

    assign pend = cos_req & grp_en & {NGRP{gen_en}};

    irq_prio_pick #(.N(NGRP), .IDX_W(IDX_W)) u_pick (
        .req(pend), .valid(req_valid), .idx(win)
    );

    irq_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iack_in(iack_in), .lvl_addr(lvl_addr),
        .own_lvl(lvl), .req_valid(req_valid), .take(take),
        .dtack(dtack), .iack_out(iack_out)
    );

    always_comb begin
        for (int k = 1; k <= NLVL; k++) begin
            irq_o[k-1] = req_valid && (lvl == LVL_W'(k));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec_q <= '0;
        else if (take) vec_q <= vec_arr[win];
    end

    assign vec_data = dtack ? vec_q : '0;

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o)) else $error("one line"); // R4
    AST_CODE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0) |-> (irq_o == '0)) else $error("code zero"); // R4
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (gen_en && |(cos_req & grp_en))) else $error("gating"); // R3
    AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack) |-> (!gen_en && irq_o == '0)) else $error("enable"); // R6
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack && $past(dtack)) |-> $stable(vec_data)) else $error("vector"); // R8
endmodule

// File: tb/tb_vme_irq_unit.sv
module tb_vme_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic [3:0]  vec_wr = '0;
    logic [15:0] vec_wdata = '0;
    logic [3:0]  cos_req = '0;
    logic [6:0]  irq_o;
    logic        iack_in = 1'b0;
    logic [2:0]  lvl_addr = '0;
    logic        iack_out;
    logic [15:0] vec_data;
    logic        dtack;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    vme_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .vec_wr(vec_wr), .vec_wdata(vec_wdata),
        .cos_req(cos_req), .irq_o(irq_o), .iack_in(iack_in), .lvl_addr(lvl_addr),
        .iack_out(iack_out), .vec_data(vec_data), .dtack(dtack)
    );

    function automatic logic [15:0] vexp(int g);
        return 16'(16'hC35A ^ (g * 16'h1111));
    endfunction

    function automatic logic [15:0] ctl_word(int lvl, int en, int g);
        return 16'((en << 8) | (lvl << 2) | (g << 1));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(logic [15:0] v);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic run_ack(int c, int en, int l, int a, bit flip_cos);
        int  win;
        int  pend;
        bit  hit;
        wr_ctl(ctl_word(l, en, 1));
        cos_req = 4'(c);
        pend = c & en;
        win = 0;
        for (int i = 3; i >= 0; i--) if (pend[i]) win = i;
        hit = (pend != 0) && (l != 0) && (a == l);
        @(negedge clk);
        iack_in = 1'b1;
        lvl_addr = 3'(a);
        @(negedge clk);
        chk("R5 dtack", 32'(dtack), 32'(hit));
        chk("R7 relay", 32'(iack_out), 32'(!hit));
        if (hit) begin
            chk("R5 vector", 32'(vec_data), 32'(vexp(win)));
            chk("R6 enable cleared", 32'(ctl_rdata[1]), 32'd0);
            chk("R6 lines drop", 32'(irq_o), 32'd0);
        end else begin
            chk("R7 enable kept", 32'(ctl_rdata[1]), 32'd1);
        end
        if (flip_cos) cos_req = 4'(~c);
        @(negedge clk);
        chk("R8 dtack held", 32'(dtack), 32'(hit));
        chk("R8 vector held", 32'(vec_data), hit ? 32'(vexp(win)) : 32'd0);
        iack_in = 1'b0;
        #1;
        chk("R9 relay drops with input", 32'(iack_out), 32'd0);
        @(negedge clk);
        chk("R8 release", 32'({dtack, vec_data}), 32'd0);
        cos_req = '0;
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl reset", 32'(ctl_rdata), 32'd0);
        chk("R1 lines reset", 32'(irq_o), 32'd0);
        chk("R1 no answer", 32'({dtack, iack_out}), 32'd0);
        // R1 vector zero after reset
        wr_ctl(ctl_word(3, 1, 1));
        cos_req = 4'd1;
        @(negedge clk);
        iack_in = 1'b1;
        lvl_addr = 3'd3;
        @(negedge clk);
        chk("R1 dtack", 32'(dtack), 32'd1);
        chk("R1 reset vector", 32'(vec_data), 32'd0);
        iack_in = 1'b0;
        cos_req = '0;
        @(negedge clk);

        // R2 clear bit and readback mask
        wr_ctl(16'hFFFE);
        chk("R2 load masks unused", 32'(ctl_rdata), 32'h0F1E);
        wr_ctl(16'hFFFF);
        chk("R2 clear wins", 32'(ctl_rdata), 32'd0);

        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            vec_wr = 4'(1 << g);
            vec_wdata = vexp(g);
        end
        @(negedge clk);
        vec_wr = '0;

        // R3 / R4 sweep
        for (int l = 0; l < 8; l++)
            for (int en = 0; en < 16; en++)
                for (int g = 0; g < 2; g++) begin
                    wr_ctl(ctl_word(l, en, g));
                    chk("R2 readback", 32'(ctl_rdata), 32'(ctl_word(l, en, g)));
                    for (int c = 0; c < 16; c++) begin
                        cos_req = 4'(c);
                        #1;
                        chk("R3 R4 lines", 32'(irq_o),
                            ((c & en) != 0 && g == 1 && l != 0) ? 32'(1 << (l - 1)) : 32'd0);
                    end
                end
        cos_req = '0;

        // R5 R6 R7 full acknowledge sweep
        for (int c = 1; c < 16; c++)
            for (int l = 1; l < 8; l++)
                for (int a = 0; a < 8; a++)
                    run_ack(c, 15, l, a, 1'b0);
        // R5 top groups masked
        run_ack(3, 4'hE, 5, 5, 1'b0);
        run_ack(15, 4'h8, 2, 2, 1'b0);
        // R7 acknowledge with nothing pending
        run_ack(0, 15, 4, 4, 1'b0);
        // R8 flags change during reply
        run_ack(4'b0110, 15, 7, 7, 1'b1);
        // R7 code zero never answers
        run_ack(1, 15, 0, 0, 1'b0);

        // R6 control write coinciding with the reply edge
        wr_ctl(ctl_word(2, 1, 1));
        cos_req = 4'd1;
        @(negedge clk);
        iack_in = 1'b1;
        lvl_addr = 3'd2;
        ctl_wr = 1'b1;
        ctl_wdata = ctl_word(2, 1, 1);
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R6 clear beats write", 32'(ctl_rdata[1]), 32'd0);
        iack_in = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule